// File: doc/BRIEF.md
# Dual-Clock Timer Register Bridge

An 8-bit timer/counter whose count, compare and control registers sit behind a small host read/write port, and whose timer can be clocked either by the host bus clock or by a separate, unrelated timer clock. A status register carries the clock-source select bit. In the asynchronous setting, each host write to a timer register is captured in a holding register and moved into the timer clock domain by a toggle handshake. A per-register busy flag stays set until the acknowledge has come back. While a flag is set, further writes to that register are refused, so a half-moved value can never land.

The counter advances on each tick of the selected clock while running. When it equals the compare value, a match flag is latched in the bus domain and drives the interrupt request. A match can also toggle a waveform pin and can restart the count from zero. A host write to the counter masks the compare on the very next tick. In the asynchronous setting the counter is read back through a continuously refreshed snapshot. Switching the clock source clears all three timer registers.

Top module: `tmr_async_bridge`

## Requirements
- R1: After reset every register reads zero (address 0 counter, 1 compare, 2 control, 3 status), and irq and wave are low.
- R2: With status bit 3 at 0 (bus clock), a register write is visible on the next bus cycle and status bits 2..0 read zero.
- R3: While control bit 0 (run) is set, the counter advances by one per tick of the selected clock, wrapping at its width. A tick whose pre-tick count equals the compare value is a match. If control bit 1 is also set, a match reloads the count with zero in place of the increment.
- R4: When control bit 2 is set, each match inverts the wave output.
- R5: The first tick after a host write to the counter produces no match, even when the written value equals the compare value.
- R6: With status bit 3 at 1, a write to the counter, compare or control register sets status bit 2, 1 or 0 respectively on the next bus cycle. The bit clears by itself once the value has reached the timer domain and been acknowledged, and the written value then reads back.
- R7: A write to a register whose busy bit is set is dropped, the register keeps its previous value, and sticky status bit 5 is set; writing 1 to bit 5 clears it.
- R8: Writing a new value to status bit 3 switches the clock source and clears the counter, compare and control registers and the wave output. If any busy bit is set, the switch is refused and status bit 5 is set.
- R9: A match in either clock setting sets status bit 4, and irq follows that bit. Writing 1 to bit 4 clears it, and a match in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| tclk | input | 1 | Asynchronous timer clock |
| wr_en | input | 1 | Register write strobe, captured on the rising edge of clk |
| addr | input | 2 | Register select: 0 counter, 1 compare, 2 control, 3 status |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for the register selected by addr, combinational |
| irq | output | 1 | Compare-match interrupt request, the latched status bit 4 |
| wave | output | 1 | Waveform output toggled on match |

## Verification
In the bus-clock setting every result lands on a fixed cycle. A write is read back on the next cycle. A run started at one write and stopped at a write N cycles later gives exactly N ticks. The match flag is latched one cycle after the matching tick. The bench therefore times its start and stop writes to the cycle and predicts exact counter values and flag states. In the timer-clock setting, the delay of a busy flag and of an interrupt depends on the phase between the two clocks. The bench checks the busy bits in the cycle right after the write, when they must already be set. It then polls status for the busy bits to drop, or for irq to rise, under a bounded wait, and only checks read-back values and blocking behaviour after that.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      A_CNT  = 2'd0,
      A_CMP  = 2'd1,
      A_CTL  = 2'd2,
      A_STAT = 2'd3
   } tmr_addr_e;

   // status bit positions (busy bits double as channel indices)
   localparam int ST_BUSY_CTL = 0;
   localparam int ST_BUSY_CMP = 1;
   localparam int ST_BUSY_CNT = 2;
   localparam int ST_SEL      = 3;
   localparam int ST_MATCH    = 4;
   localparam int ST_ERR      = 5;
   localparam int ST_BITS     = 6;

   // control bit positions
   localparam int CTL_RUN = 0;
   localparam int CTL_CLR = 1;
   localparam int CTL_TOG = 2;

   localparam int NCHAN = 3;

   function automatic logic [1:0] chan_addr(input int ch);
      case (ch)
         ST_BUSY_CNT: chan_addr = A_CNT;
         ST_BUSY_CMP: chan_addr = A_CMP;
         default:     chan_addr = A_CTL;
      endcase
   endfunction
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/tmr_mbox.sv
module tmr_mbox #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_s,
   input  logic         clk_d,
   input  logic         rst_n,
   input  logic         s_send,
   input  logic [W-1:0] s_data,
   output logic         s_busy,
   output logic         d_load,
   output logic [W-1:0] d_data
);
   logic         req_t;
   logic         ack_t;
   logic         ack_s;
   logic         req_d;
   logic [W-1:0] hold;

   // source side: capture and flip the request
   always_ff @(posedge clk_s or negedge rst_n) begin
      if (!rst_n) begin
         req_t <= 1'b0;
         hold  <= '0;
      end else if (s_send && !s_busy) begin
         req_t <= ~req_t;
         hold  <= s_data;
      end
   end

   tmr_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
      .clk(clk_s), .rst_n(rst_n), .d(ack_t), .q(ack_s)
   );

   assign s_busy = req_t ^ ack_s;

   // destination side: a request edge loads the held word and is echoed
   tmr_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
      .clk(clk_d), .rst_n(rst_n), .d(req_t), .q(req_d)
   );

   always_ff @(posedge clk_d or negedge rst_n) begin
      if (!rst_n)      ack_t <= 1'b0;
      else if (d_load) ack_t <= req_d;
   end

   assign d_load = req_d ^ ack_t;
   assign d_data = hold;
endmodule

// File: rtl/tmr_pulse_xing.sv
module tmr_pulse_xing #(
   parameter int STAGES = 2
) (
   input  logic clk_s,
   input  logic clk_d,
   input  logic rst_n,
   input  logic s_pulse,
   output logic d_pulse
);
   logic tgl_s;
   logic tgl_d;
   logic tgl_q;

   always_ff @(posedge clk_s or negedge rst_n) begin
      if (!rst_n)       tgl_s <= 1'b0;
      else if (s_pulse) tgl_s <= ~tgl_s;
   end

   tmr_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk(clk_d), .rst_n(rst_n), .d(tgl_s), .q(tgl_d)
   );

   always_ff @(posedge clk_d or negedge rst_n) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= tgl_d;
   end

   assign d_pulse = tgl_d ^ tgl_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ld_cnt,
   input  logic             ld_cmp,
   input  logic             ld_ctl,
   input  logic [WIDTH-1:0] d_cnt,
   input  logic [WIDTH-1:0] d_cmp,
   input  logic [WIDTH-1:0] d_ctl,
   output logic [WIDTH-1:0] cnt,
   output logic             match,
   output logic             wave
);
   logic [WIDTH-1:0] cmp;
   logic [WIDTH-1:0] ctl;
   logic             blk;
   logic             hit;
   logic             unused_ctl;

   assign unused_ctl = ^ctl[WIDTH-1:CTL_TOG+1];
   assign hit        = ctl[CTL_RUN] && (cnt == cmp) && !blk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         cmp   <= '0;
         ctl   <= '0;
         blk   <= 1'b0;
         match <= 1'b0;
         wave  <= 1'b0;
      end else if (clr) begin
         cnt   <= '0;
         cmp   <= '0;
         ctl   <= '0;
         blk   <= 1'b0;
         match <= 1'b0;
         wave  <= 1'b0;
      end else begin
         match <= 1'b0;
         if (ld_cmp) cmp <= d_cmp;
         if (ld_ctl) ctl <= d_ctl;
         if (ld_cnt) begin
            cnt <= d_cnt;
            blk <= 1'b1;
         end else if (ctl[CTL_RUN]) begin
            blk   <= 1'b0;
            match <= hit;
            if (hit && ctl[CTL_TOG]) wave <= ~wave;
            if (hit && ctl[CTL_CLR]) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_async_bridge.sv
module tmr_async_bridge
   import tmr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tclk,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             irq,
   output logic             wave
);
   if (WIDTH < ST_BITS) begin : g_bad_width
      $error("tmr_async_bridge: WIDTH must hold the status bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("tmr_async_bridge: SYNC_STAGES must be at least 2");
   end

   // ---------------- bus-domain state ----------------
   logic             sel_q;
   logic [WIDTH-1:0] sh_cmp;
   logic [WIDTH-1:0] sh_ctl;
   logic [WIDTH-1:0] snap_q;
   logic             err_q;
   logic             flag_q;

   logic [NCHAN-1:0] busy;
   logic [NCHAN-1:0] wr_reg;
   logic [NCHAN-1:0] accept;
   logic [NCHAN-1:0] reject;
   logic [NCHAN-1:0] chan_send;
   logic [NCHAN-1:0] s_ld;

   logic             wr_stat;
   logic             mode_req;
   logic             mode_ok;
   logic             mode_bad;
   logic             flag_set;

   // ---------------- timer-domain nets ----------------
   logic [NCHAN-1:0] t_ld;
   logic [WIDTH-1:0] t_d [NCHAN];
   logic             sel_t;
   logic [WIDTH-1:0] a_cnt;
   logic             a_match;
   logic             a_wave;
   logic             a_irq;
   logic [WIDTH-1:0] s_cnt;
   logic             s_match;
   logic             s_wave;
   logic             s_ld_cnt;
   logic             snap_ld;
   logic [WIDTH-1:0] snap_d;
   logic             snap_busy_unused;

   // ---------------- write decode ----------------
   for (genvar i = 0; i < NCHAN; i++) begin : g_dec
      assign wr_reg[i]    = wr_en && (addr == chan_addr(i));
      assign reject[i]    = wr_reg[i] && sel_q && busy[i];
      assign accept[i]    = wr_reg[i] && !reject[i];
      assign chan_send[i] = accept[i] && sel_q;
      assign s_ld[i]      = accept[i] && !sel_q;
   end

   assign s_ld_cnt = s_ld[ST_BUSY_CNT];
   assign wr_stat  = wr_en && (addr == A_STAT);
   assign mode_req = wr_stat && (wdata[ST_SEL] != sel_q);
   assign mode_ok  = mode_req && (busy == '0);
   assign mode_bad = mode_req && (busy != '0);
   assign flag_set = sel_q ? a_irq : s_match;

   // ---------------- bus-domain registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         sh_cmp <= '0;
         sh_ctl <= '0;
         snap_q <= '0;
         err_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (mode_ok) sel_q <= ~sel_q;

         if (mode_ok)                  sh_cmp <= '0;
         else if (accept[ST_BUSY_CMP]) sh_cmp <= wdata;

         if (mode_ok)                  sh_ctl <= '0;
         else if (accept[ST_BUSY_CTL]) sh_ctl <= wdata;

         if (mode_ok)      snap_q <= '0;
         else if (snap_ld) snap_q <= snap_d;

         if ((reject != '0) || mode_bad)  err_q <= 1'b1;
         else if (wr_stat && wdata[ST_ERR]) err_q <= 1'b0;

         if (flag_set)                        flag_q <= 1'b1;
         else if (wr_stat && wdata[ST_MATCH]) flag_q <= 1'b0;
      end
   end

   // ---------------- bus-clock timer ----------------
   tmr_core #(.WIDTH(WIDTH)) u_core_bus (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sel_q),
      .ld_cnt (s_ld[ST_BUSY_CNT]),
      .ld_cmp (s_ld[ST_BUSY_CMP]),
      .ld_ctl (s_ld[ST_BUSY_CTL]),
      .d_cnt  (wdata),
      .d_cmp  (wdata),
      .d_ctl  (wdata),
      .cnt    (s_cnt),
      .match  (s_match),
      .wave   (s_wave)
   );

   // ---------------- crossings into the timer domain ----------------
   for (genvar i = 0; i < NCHAN; i++) begin : g_chan
      tmr_mbox #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_mbox (
         .clk_s  (clk),
         .clk_d  (tclk),
         .rst_n  (rst_n),
         .s_send (chan_send[i]),
         .s_data (wdata),
         .s_busy (busy[i]),
         .d_load (t_ld[i]),
         .d_data (t_d[i])
      );
   end

   tmr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sel_sync (
      .clk(tclk), .rst_n(rst_n), .d(sel_q), .q(sel_t)
   );

   // ---------------- timer-clock timer ----------------
   tmr_core #(.WIDTH(WIDTH)) u_core_tmr (
      .clk    (tclk),
      .rst_n  (rst_n),
      .clr    (!sel_t),
      .ld_cnt (t_ld[ST_BUSY_CNT]),
      .ld_cmp (t_ld[ST_BUSY_CMP]),
      .ld_ctl (t_ld[ST_BUSY_CTL]),
      .d_cnt  (t_d[ST_BUSY_CNT]),
      .d_cmp  (t_d[ST_BUSY_CMP]),
      .d_ctl  (t_d[ST_BUSY_CTL]),
      .cnt    (a_cnt),
      .match  (a_match),
      .wave   (a_wave)
   );

   // ---------------- crossings back to the bus domain ----------------
   tmr_mbox #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_snap (
      .clk_s  (tclk),
      .clk_d  (clk),
      .rst_n  (rst_n),
      .s_send (1'b1),
      .s_data (a_cnt),
      .s_busy (snap_busy_unused),
      .d_load (snap_ld),
      .d_data (snap_d)
   );

   tmr_pulse_xing #(.STAGES(SYNC_STAGES)) u_irq_xing (
      .clk_s   (tclk),
      .clk_d   (clk),
      .rst_n   (rst_n),
      .s_pulse (a_match),
      .d_pulse (a_irq)
   );

   // ---------------- read mux and outputs ----------------
   always_comb begin
      rdata = '0;
      case (addr)
         A_CNT:   rdata = sel_q ? snap_q : s_cnt;
         A_CMP:   rdata = sh_cmp;
         A_CTL:   rdata = sh_ctl;
         default: begin
            rdata[ST_BUSY_CNT] = busy[ST_BUSY_CNT];
            rdata[ST_BUSY_CMP] = busy[ST_BUSY_CMP];
            rdata[ST_BUSY_CTL] = busy[ST_BUSY_CTL];
            rdata[ST_SEL]      = sel_q;
            rdata[ST_MATCH]    = flag_q;
            rdata[ST_ERR]      = err_q;
         end
      endcase
   end

   assign irq  = flag_q;
   assign wave = sel_q ? a_wave : s_wave;
endmodule

// File: rtl/tmr_async_bridge_chk.sv
module tmr_async_bridge_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [WIDTH-1:0] wdata,
   input logic             sel_q,
   input logic [2:0]       busy,
   input logic [WIDTH-1:0] sh_cmp,
   input logic [WIDTH-1:0] sh_ctl,
   input logic             err_q,
   input logic             flag_set,
   input logic             s_ld_cnt,
   input logic             s_match,
   input logic             irq
);
   // R2: no handshake is ever pending in the bus-clock setting
   a_r2_sync_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |-> (busy == 3'b000));

   // R6: an accepted compare write in the timer-clock setting raises its busy bit
   a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1 && sel_q && !busy[1]) |=> busy[1]);

   // R7: a compare write while busy leaves the value and sets the error bit
   a_r7_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1 && sel_q && busy[1]) |=> ($stable(sh_cmp) && err_q));

   // R8: a source switch empties compare and control
   a_r8_switch_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q != $past(sel_q)) |-> (sh_cmp == '0 && sh_ctl == '0));

   // R8: a switch requested during a pending transfer is refused
   a_r8_switch_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && (wdata[3] != sel_q) && (busy != 3'b000))
      |=> ($stable(sel_q) && err_q));

   // R5: the tick right after a counter write never matches
   a_r5_block_next: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(s_ld_cnt) && !s_ld_cnt) |=> !s_match);

   // R9: a clear of the match bit without a new match drops irq
   a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[4] && !flag_set) |=> !irq);
endmodule

bind tmr_async_bridge tmr_async_bridge_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .sel_q    (sel_q),
   .busy     (busy),
   .sh_cmp   (sh_cmp),
   .sh_ctl   (sh_ctl),
   .err_q    (err_q),
   .flag_set (flag_set),
   .s_ld_cnt (s_ld_cnt),
   .s_match  (s_match),
   .irq      (irq)
);

// File: tb/tb_tmr_async_bridge.sv
`timescale 1ns/1ps
module tb_tmr_async_bridge;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         tclk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq;
   logic         wave;

   always #4 clk = ~clk;
   always #18.5 tclk = ~tclk;

   tmr_async_bridge #(.WIDTH(W), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .tclk(tclk), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .wave(wave)
   );

   typedef struct {
      int           kind;   // 0 rdata, 1 irq, 2 wave
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   item_t q[$];
   logic  mon_arm = 1'b0;
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   // monitor: pops expected items and compares away from the clock edge
   always @(negedge clk) begin
      if (mon_arm && q.size() > 0) begin
         item_t it;
         logic [W-1:0] act;
         it = q.pop_front();
         act = (it.kind == 0) ? rdata : (it.kind == 1) ? {{(W-1){1'b0}}, irq}
                                                       : {{(W-1){1'b0}}, wave};
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   // all tasks are entered 1 ns after a rising clk edge
   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic expect_out(input int kind, input logic [1:0] a,
                             input logic [W-1:0] e, input string tag);
      item_t it;
      it.kind = kind; it.exp = e; it.tag = tag;
      addr = a;
      q.push_back(it);
      mon_arm = 1'b1;
      @(negedge clk); #1;
      mon_arm = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_idle(input string tag);
      bit ok = 1'b0;
      addr = 2'd3;
      for (int i = 0; i < 500 && !ok; i++) begin
         @(negedge clk);
         if (rdata[2:0] == 3'b000) ok = 1'b1;
         @(posedge clk); #1;
      end
      if (!ok) begin
         total++; bad++;
         $display("FAIL %s: busy bits actual=%b expected=000", tag, rdata[2:0]);
      end
   endtask

   task automatic wait_irq(input string tag);
      bit ok = 1'b0;
      for (int i = 0; i < 2000 && !ok; i++) begin
         @(negedge clk);
         if (irq) ok = 1'b1;
         @(posedge clk); #1;
      end
      if (!ok) begin
         total++; bad++;
         $display("FAIL %s: irq actual=0 expected=1", tag);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not end, actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      expect_out(0, 2'd0, 8'h00, "R1 counter after reset");
      expect_out(0, 2'd1, 8'h00, "R1 compare after reset");
      expect_out(0, 2'd2, 8'h00, "R1 control after reset");
      expect_out(0, 2'd3, 8'h00, "R1 status after reset");
      expect_out(1, 2'd3, 8'h00, "R1 irq after reset");
      expect_out(2, 2'd3, 8'h00, "R1 wave after reset");

      // R2 bus-clock writes
      wr(2'd1, 8'h20);
      expect_out(0, 2'd1, 8'h20, "R2 compare readback");
      expect_out(0, 2'd3, 8'h00, "R2 busy bits stay zero");

      // R5 + R3: counter equal to compare, first tick masked, 20 ticks
      wr(2'd0, 8'h20);
      wr(2'd2, 8'h01);
      idle(19);
      wr(2'd2, 8'h00);
      expect_out(0, 2'd3, 8'h00, "R5 no match after counter write");
      expect_out(0, 2'd0, 8'h34, "R3 counter after 20 ticks");

      // R3/R4/R9: match on the second tick, toggle enabled
      wr(2'd0, 8'h1F);
      wr(2'd2, 8'h05);
      idle(9);
      wr(2'd2, 8'h00);
      expect_out(0, 2'd0, 8'h29, "R3 counter after 10 ticks");
      expect_out(0, 2'd3, 8'h10, "R9 match bit set");
      expect_out(1, 2'd3, 8'h01, "R9 irq high on match");
      expect_out(2, 2'd3, 8'h01, "R4 wave toggled");
      wr(2'd3, 8'h10);
      expect_out(0, 2'd3, 8'h00, "R9 match bit cleared by write 1");
      expect_out(1, 2'd3, 8'h00, "R9 irq low after clear");

      // R3 clear on match: compare 3, 10 ticks from 0 -> 2
      wr(2'd1, 8'h03);
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h03);
      idle(9);
      wr(2'd2, 8'h00);
      expect_out(0, 2'd0, 8'h02, "R3 clear-on-match count");
      expect_out(2, 2'd3, 8'h01, "R4 wave held without toggle bit");
      wr(2'd3, 8'h10);

      // R8 switch to the timer clock
      wr(2'd3, 8'h08);
      expect_out(0, 2'd3, 8'h08, "R8 select bit set");
      idle(20);
      expect_out(0, 2'd1, 8'h00, "R8 compare cleared");
      expect_out(0, 2'd0, 8'h00, "R8 counter cleared");
      expect_out(2, 2'd3, 8'h00, "R8 wave cleared");

      // R6/R7 staged write and write while busy
      wr(2'd1, 8'h07);
      wr(2'd1, 8'h55);
      expect_out(0, 2'd3, 8'h2A, "R6 busy compare, R7 error set");
      wait_idle("R6 compare transfer");
      expect_out(0, 2'd1, 8'h07, "R7 second write dropped");
      wr(2'd3, 8'h28);
      expect_out(0, 2'd3, 8'h08, "R7 error cleared");

      // R6 counter and control busy, then async match
      wr(2'd0, 8'h06);
      wr(2'd2, 8'h05);
      expect_out(0, 2'd3, 8'h0D, "R6 busy counter and control");
      wait_idle("R6 counter/control transfer");
      expect_out(0, 2'd2, 8'h05, "R6 control readback");
      wait_irq("R9 async match");
      expect_out(1, 2'd3, 8'h01, "R9 irq in timer-clock setting");
      expect_out(2, 2'd3, 8'h01, "R4 wave toggled in timer-clock setting");
      wr(2'd2, 8'h00);
      wait_idle("R6 stop transfer");
      wr(2'd3, 8'h18);
      expect_out(0, 2'd3, 8'h08, "R9 flag cleared async");

      // R8 switch refused while busy
      wr(2'd1, 8'h07);
      wr(2'd3, 8'h00);
      expect_out(0, 2'd3, 8'h2A, "R8 switch refused while busy");
      wait_idle("R8 pending transfer");
      wr(2'd3, 8'h28);
      expect_out(0, 2'd3, 8'h08, "R8 still timer clock");

      // R5 in the timer-clock setting
      wr(2'd0, 8'h07);
      wait_idle("R5 counter transfer");
      wr(2'd2, 8'h01);
      wait_idle("R5 control transfer");
      idle(60);
      expect_out(0, 2'd3, 8'h08, "R5 no match after async counter write");
      expect_out(1, 2'd3, 8'h00, "R5 irq low async");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule